// File: doc/BRIEF.md
# OUT Endpoint Receive Bank Manager

This block handles receive buffering for a bulk or interrupt OUT endpoint that has several data banks (two by default). The packet engine streams each OUT packet into the block. The block decides whether the packet is accepted or refused:

- A packet is accepted when the endpoint is enabled and the next bank in ring order is free.
- An accepted packet is written into that bank, and the block answers with an acknowledge pulse.
- A refused packet is dropped, and the block answers with a refuse (NAK) pulse.

Each filled bank is then offered to the CPU through a read port. While a bank is offered, an ownership bit and a received-packet flag are set. The received-packet flag raises an interrupt request when interrupts are enabled.

The CPU has two separate actions for each bank. Clearing the received-packet flag only acknowledges the interrupt. Releasing the bank hands it back to the host side and moves the CPU to the next bank in ring order. If that next bank is already full, it is offered at once. Each bank records its own byte count. The CPU sees the count of the bank it is reading, and its read pointer starts again at zero on every new bank.

Top module: `out_ep_bank_mgr`

## Requirements
- R1: After reset, `rx_flag`, `cpu_owns`, `irq`, `hs_ack`, `hs_nak` and `byte_cnt` are all zero, and every bank is free.
- R2: A packet is accepted only when `ep_enable` is 1 and the next bank in ring order is free, both sampled in the `rx_start` cycle. In the cycle after `rx_done`, `hs_ack` pulses for an accepted packet and `hs_nak` pulses for a refused one. The two never pulse together, and a refused packet changes no bank.
- R3: When a bank is filled and the CPU owns no bank, `cpu_owns` and `rx_flag` rise at the second rising edge after the cycle in which `rx_done` is sampled.
- R4: `irq` equals `rx_flag` AND `irq_en`, both taken at the previous rising edge.
- R5: A one-cycle pulse on `clr_rx_flag` clears `rx_flag` at the next edge. It leaves `cpu_owns`, the offered bank and its data unchanged.
- R6: A pulse on `release_bank` while `cpu_owns` is 1 clears `cpu_owns` at the next edge. If the next bank in ring order is already full, `cpu_owns` and `rx_flag` are set again one edge later. A `release_bank` pulse while `cpu_owns` is 0 is ignored.
- R7: Banks are filled and offered in the same ring order, so the CPU reads packets in arrival order, with bytes in arrival order.
- R8: While `cpu_owns` is 1, `byte_cnt` shows the byte count of the offered bank, and it is 0 otherwise. Bytes beyond `BANK_BYTES` in one packet are dropped, and the count stops at `BANK_BYTES`. A zero-length packet fills a bank with count 0.
- R9: `rd_en` while `cpu_owns` is 1 returns the next byte on `rd_data` one cycle later. The read position is 0 for each newly offered bank. `rd_en` while `cpu_owns` is 0 does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_enable | input | 1 | Endpoint enabled; packets are refused while 0 |
| irq_en | input | 1 | Interrupt enable for the received-packet flag |
| rx_start | input | 1 | One-cycle pulse at the start of an OUT packet |
| rx_valid | input | 1 | A data byte is present on `rx_byte` |
| rx_byte | input | 8 | Packet data byte |
| rx_done | input | 1 | One-cycle pulse at the end of the packet |
| hs_ack | output | 1 | Acknowledge pulse for an accepted packet |
| hs_nak | output | 1 | NAK pulse for a refused packet |
| clr_rx_flag | input | 1 | CPU clears the received-packet flag |
| release_bank | input | 1 | CPU returns the offered bank to the host side |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| byte_cnt | output | $clog2(BANK_BYTES+1) | Byte count of the offered bank |
| rx_flag | output | 1 | Received-packet flag |
| cpu_owns | output | 1 | The CPU owns the offered bank |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the packet engine frames packets cleanly. `rx_start`, the `rx_valid` beats and `rx_done` come in separate cycles, in that order, and one packet ends before the next starts. They also assume that the CPU never pulses `rd_en` and `release_bank` in the same cycle. The stimulus is built from tasks that send a whole packet or perform a single CPU action, so these rules always hold. The stimulus still covers the awkward orders: a packet that arrives while both banks are full, releases and reads while the CPU owns no bank, an oversize packet and a zero-length packet.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

  typedef logic [7:0] ep_byte_t;

  // next bank index in ring order
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned nbanks);
    return (idx + 1 >= nbanks) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/ep_bank_ram.sv
module ep_bank_ram #(
  parameter int NBANK = 2,
  parameter int DEPTH = 64,
  localparam int WORDS = NBANK * DEPTH,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  out_ep_pkg::ep_byte_t   wdata,
  input  logic                   re,
  input  logic [AW-1:0]          raddr,
  output out_ep_pkg::ep_byte_t   rdata
);
  out_ep_pkg::ep_byte_t mem [WORDS];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_bank_ledger.sv
module ep_bank_ledger #(
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] set_full,
  input  logic [NBANK-1:0] clr_full,
  output logic [NBANK-1:0] full
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)              full[b] <= 1'b0;
      else if (set_full[b]) full[b] <= 1'b1;
      else if (clr_full[b]) full[b] <= 1'b0;
    end

    // R2: the host side only fills a bank that is free
    a_r2_fill_only_free: assert property (@(posedge clk) disable iff (rst)
      set_full[b] |-> !full[b]);
    // R6: the CPU side only releases a bank that holds data
    a_r6_release_only_full: assert property (@(posedge clk) disable iff (rst)
      clr_full[b] |-> full[b]);
  end
endmodule

// File: rtl/ep_host_fill.sv
module ep_host_fill #(
  parameter int NBANK = 2,
  parameter int DEPTH = 64,
  localparam int WORDS = NBANK * DEPTH,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ep_enable,
  input  logic                         rx_start,
  input  logic                         rx_valid,
  input  out_ep_pkg::ep_byte_t         rx_byte,
  input  logic                         rx_done,
  input  logic [NBANK-1:0]             full,
  output logic [NBANK-1:0]             set_full,
  output logic                         we,
  output logic [AW-1:0]                waddr,
  output out_ep_pkg::ep_byte_t         wdata,
  output logic [NBANK-1:0][CW-1:0]     bank_cnt,
  output logic                         hs_ack,
  output logic                         hs_nak
);
  logic          taking;
  logic [BW-1:0] hbank;
  logic [CW-1:0] wcnt;
  logic          room;

  assign room  = (wcnt < CW'(DEPTH));
  assign we    = rx_valid && taking && !rx_start && room;
  assign waddr = AW'(hbank) * AW'(DEPTH) + AW'(wcnt);
  assign wdata = rx_byte;

  for (genvar b = 0; b < NBANK; b++) begin : g_set
    assign set_full[b] = rx_done && taking && (hbank == BW'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taking   <= 1'b0;
      hbank    <= '0;
      wcnt     <= '0;
      bank_cnt <= '0;
      hs_ack   <= 1'b0;
      hs_nak   <= 1'b0;
    end else begin
      hs_ack <= 1'b0;
      hs_nak <= 1'b0;
      if (rx_start) begin
        taking <= ep_enable && !full[hbank];
        wcnt   <= '0;
      end else if (we) begin
        wcnt <= wcnt + 1'b1;
      end
      if (rx_done) begin
        hs_ack <= taking;
        hs_nak <= !taking;
        taking <= 1'b0;
        if (taking) begin
          bank_cnt[hbank] <= wcnt;
          hbank <= BW'(out_ep_pkg::ring_next(32'(hbank), NBANK));
        end
      end
    end
  end

  // R2: one handshake per packet, never both
  a_r2_one_handshake: assert property (@(posedge clk) disable iff (rst)
    !(hs_ack && hs_nak));
  // R8: the fill position never passes the bank size
  a_r8_count_capped: assert property (@(posedge clk) disable iff (rst)
    wcnt <= CW'(DEPTH));
endmodule

// File: rtl/ep_cpu_drain.sv
module ep_cpu_drain #(
  parameter int NBANK = 2,
  parameter int DEPTH = 64,
  localparam int WORDS = NBANK * DEPTH,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     irq_en,
  input  logic                     clr_rx_flag,
  input  logic                     release_bank,
  input  logic                     rd_en,
  input  logic [NBANK-1:0]         full,
  input  logic [NBANK-1:0][CW-1:0] bank_cnt,
  output logic [NBANK-1:0]         clr_full,
  output logic                     re,
  output logic [AW-1:0]            raddr,
  output logic                     rx_flag,
  output logic                     cpu_owns,
  output logic                     irq,
  output logic [CW-1:0]            byte_cnt
);
  logic [BW-1:0] cbank;
  logic [CW-1:0] rptr;
  logic          offer;
  logic          give_back;
  logic          flag_nxt;

  assign offer     = !cpu_owns && full[cbank];
  assign give_back = cpu_owns && release_bank;
  assign re        = cpu_owns && rd_en;
  assign raddr     = AW'(cbank) * AW'(DEPTH) + AW'(rptr);
  assign flag_nxt  = offer ? 1'b1 : (clr_rx_flag ? 1'b0 : rx_flag);

  for (genvar b = 0; b < NBANK; b++) begin : g_clr
    assign clr_full[b] = give_back && (cbank == BW'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cbank    <= '0;
      rptr     <= '0;
      cpu_owns <= 1'b0;
      rx_flag  <= 1'b0;
      irq      <= 1'b0;
      byte_cnt <= '0;
    end else begin
      rx_flag <= flag_nxt;
      irq     <= flag_nxt && irq_en;
      if (give_back) begin
        cpu_owns <= 1'b0;
        cbank    <= BW'(out_ep_pkg::ring_next(32'(cbank), NBANK));
        rptr     <= '0;
        byte_cnt <= '0;
      end else if (offer) begin
        cpu_owns <= 1'b1;
        byte_cnt <= bank_cnt[cbank];
      end else if (re && rptr != CW'(DEPTH)) begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  // R3: the CPU only ever owns a bank that the ledger marks full
  a_r3_owned_is_full: assert property (@(posedge clk) disable iff (rst)
    cpu_owns |-> full[cbank]);
  // R3: offering a bank always raises the flag with it
  a_r3_offer_raises_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_owns) |-> rx_flag);
  // R4: no interrupt request without the flag
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_flag);
  // R5: acknowledging the flag keeps the bank owned
  a_r5_ack_keeps_bank: assert property (@(posedge clk) disable iff (rst)
    (cpu_owns && clr_rx_flag && !release_bank) |=> cpu_owns);
  // R8: no offered bank, no count shown
  a_r8_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
    !cpu_owns |-> (byte_cnt == '0));
endmodule

// File: rtl/out_ep_bank_mgr.sv
module out_ep_bank_mgr #(
  parameter int NBANK      = 2,
  parameter int BANK_BYTES = 64,
  localparam int WORDS = NBANK * BANK_BYTES,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ep_enable,
  input  logic          irq_en,
  input  logic          rx_start,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_done,
  output logic          hs_ack,
  output logic          hs_nak,
  input  logic          clr_rx_flag,
  input  logic          release_bank,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] byte_cnt,
  output logic          rx_flag,
  output logic          cpu_owns,
  output logic          irq
);
  logic [NBANK-1:0]         full;
  logic [NBANK-1:0]         set_full;
  logic [NBANK-1:0]         clr_full;
  logic [NBANK-1:0][CW-1:0] bank_cnt;
  logic                     we;
  logic                     re;
  logic [AW-1:0]            waddr;
  logic [AW-1:0]            raddr;
  out_ep_pkg::ep_byte_t     wdata;

  ep_host_fill #(.NBANK(NBANK), .DEPTH(BANK_BYTES)) u_fill (
    .clk(clk), .rst(rst), .ep_enable(ep_enable),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_done(rx_done),
    .full(full), .set_full(set_full), .we(we), .waddr(waddr), .wdata(wdata),
    .bank_cnt(bank_cnt), .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  ep_bank_ledger #(.NBANK(NBANK)) u_ledger (
    .clk(clk), .rst(rst), .set_full(set_full), .clr_full(clr_full), .full(full)
  );

  ep_cpu_drain #(.NBANK(NBANK), .DEPTH(BANK_BYTES)) u_drain (
    .clk(clk), .rst(rst), .irq_en(irq_en), .clr_rx_flag(clr_rx_flag),
    .release_bank(release_bank), .rd_en(rd_en), .full(full), .bank_cnt(bank_cnt),
    .clr_full(clr_full), .re(re), .raddr(raddr), .rx_flag(rx_flag),
    .cpu_owns(cpu_owns), .irq(irq), .byte_cnt(byte_cnt)
  );

  ep_bank_ram #(.NBANK(NBANK), .DEPTH(BANK_BYTES)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/tb_out_ep_bank_mgr.sv
`timescale 1ns/1ps
module tb_out_ep_bank_mgr;
  localparam int NB = 2;
  localparam int D  = 64;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ep_enable = 1'b0, irq_en = 1'b0;
  logic rx_start = 1'b0, rx_valid = 1'b0, rx_done = 1'b0;
  logic [7:0] rx_byte = '0;
  logic clr_rx_flag = 1'b0, release_bank = 1'b0, rd_en = 1'b0;
  logic hs_ack, hs_nak, rx_flag, cpu_owns, irq;
  logic [7:0] rd_data;
  logic [CW-1:0] byte_cnt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  out_ep_bank_mgr #(.NBANK(NB), .BANK_BYTES(D)) dut (
    .clk(clk), .rst(rst), .ep_enable(ep_enable), .irq_en(irq_en),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_done(rx_done),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .clr_rx_flag(clr_rx_flag),
    .release_bank(release_bank), .rd_en(rd_en), .rd_data(rd_data),
    .byte_cnt(byte_cnt), .rx_flag(rx_flag), .cpu_owns(cpu_owns), .irq(irq)
  );

  // behavioural reference model
  int m_data [NB][D];
  int m_cnt [NB];
  bit m_full [NB];
  bit m_acc, m_ack, m_nak, m_own, m_flag, m_irq, m_rdv;
  int m_hb, m_cb, m_wc, m_rp, m_bc, m_rd;

  always @(posedge clk) begin
    bit old_full [NB];
    bit old_own, offer;
    int old_cb;
    if (rst) begin
      for (int b = 0; b < NB; b++) begin m_full[b] = 0; m_cnt[b] = 0; end
      m_acc = 0; m_ack = 0; m_nak = 0; m_own = 0; m_flag = 0; m_irq = 0; m_rdv = 0;
      m_hb = 0; m_cb = 0; m_wc = 0; m_rp = 0; m_bc = 0; m_rd = 0;
    end else begin
      old_full = m_full; old_own = m_own; old_cb = m_cb;
      m_ack = 0; m_nak = 0;
      if (rx_start) begin
        m_acc = ep_enable && !old_full[m_hb];
        m_wc = 0;
      end else if (rx_valid && m_acc && m_wc < D) begin
        m_data[m_hb][m_wc] = int'(rx_byte);
        m_wc++;
      end
      if (rx_done) begin
        m_ack = m_acc; m_nak = !m_acc;
        if (m_acc) begin
          m_full[m_hb] = 1; m_cnt[m_hb] = m_wc; m_hb = (m_hb + 1) % NB;
        end
        m_acc = 0;
      end
      offer = !old_own && old_full[old_cb];
      m_rdv = 0;
      if (old_own && rd_en) begin m_rd = m_data[old_cb][m_rp]; m_rdv = 1; end
      if (old_own && release_bank) begin
        m_full[old_cb] = 0; m_cb = (old_cb + 1) % NB; m_own = 0; m_bc = 0; m_rp = 0;
      end else if (offer) begin
        m_own = 1; m_bc = m_cnt[old_cb];
      end else if (old_own && rd_en && m_rp < D) begin
        m_rp++;
      end
      m_flag = offer ? 1'b1 : (clr_rx_flag ? 1'b0 : m_flag);
      m_irq = m_flag && irq_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(hs_ack == m_ack, "R2 hs_ack", int'(hs_ack), int'(m_ack));
    chk(hs_nak == m_nak, "R2 hs_nak", int'(hs_nak), int'(m_nak));
    chk(cpu_owns == m_own, "R3 cpu_owns", int'(cpu_owns), int'(m_own));
    chk(rx_flag == m_flag, "R3 rx_flag", int'(rx_flag), int'(m_flag));
    chk(irq == m_irq, "R4 irq", int'(irq), int'(m_irq));
    chk(int'(byte_cnt) == m_bc, "R8 byte_cnt", int'(byte_cnt), m_bc);
    if (m_rdv) chk(int'(rd_data) == m_rd, "R9 rd_data", int'(rd_data), m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic send(input int n, input int base);
    rx_start = 1; tick(); rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = 8'((base + i) & 255); tick();
    end
    rx_valid = 0;
    rx_done = 1; tick(); rx_done = 0;
  endtask

  task automatic pulse_release();
    release_bank = 1; tick(); release_bank = 0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    chk(!rx_flag && !cpu_owns && !irq && !hs_ack && !hs_nak && byte_cnt == 0,
        "R1 reset", int'({rx_flag, cpu_owns, irq, hs_ack, hs_nak}), 0);

    // R2: disabled endpoint refuses
    irq_en = 1;
    send(4, 8'h10);
    chk(hs_nak == 1, "R2 nak disabled", int'(hs_nak), 1);
    repeat (3) tick();
    chk(cpu_owns == 0, "R2 refused packet kept out", int'(cpu_owns), 0);

    // R3/R4: first packet offered after two edges
    ep_enable = 1;
    send(5, 8'hA0);
    chk(cpu_owns == 0, "R3 not yet owned", int'(cpu_owns), 0);
    tick();
    chk(cpu_owns == 1 && byte_cnt == 5, "R3 offered", int'(byte_cnt), 5);
    tick();
    chk(irq == 1, "R4 irq raised", int'(irq), 1);

    // second bank filled, third packet refused
    send(3, 8'hB0);
    chk(hs_ack == 1, "R2 second bank ack", int'(hs_ack), 1);
    send(2, 8'hC0);
    chk(hs_nak == 1, "R2 both full nak", int'(hs_nak), 1);

    // R5: acknowledging the flag keeps ownership
    clr_rx_flag = 1; tick(); clr_rx_flag = 0;
    chk(rx_flag == 0 && cpu_owns == 1, "R5 flag cleared bank kept", int'(cpu_owns), 1);
    tick();
    chk(irq == 0, "R5 irq dropped", int'(irq), 0);

    // R7: read first packet in order
    for (int i = 0; i < 5; i++) begin
      rd_en = 1; tick(); rd_en = 0; tick();
      chk(int'(rd_data) == 8'hA0 + i, "R7 packet order", int'(rd_data), 8'hA0 + i);
    end

    // R6: release, next full bank offered one edge later
    pulse_release();
    chk(cpu_owns == 0, "R6 released", int'(cpu_owns), 0);
    tick();
    chk(cpu_owns == 1 && rx_flag == 1 && byte_cnt == 3, "R6 reoffered", int'(byte_cnt), 3);
    rd_en = 1; tick(); rd_en = 0;
    chk(int'(rd_data) == 8'hB0, "R9 pointer restart", int'(rd_data), 8'hB0);
    pulse_release();
    clr_rx_flag = 1; tick(); clr_rx_flag = 0;
    repeat (2) tick();
    chk(cpu_owns == 0, "R6 no further bank", int'(cpu_owns), 0);

    // R6/R9: actions while no bank is owned are ignored
    rd_en = 1; tick(); rd_en = 0;
    pulse_release();
    tick();
    chk(cpu_owns == 0 && rx_flag == 0, "R6 idle release ignored", int'(cpu_owns), 0);

    // R8: oversize packet capped
    send(70, 0);
    repeat (2) tick();
    chk(int'(byte_cnt) == D, "R8 capped count", int'(byte_cnt), D);
    for (int i = 0; i < D; i++) begin
      rd_en = 1; tick(); rd_en = 0;
      if (i == 0) chk(int'(rd_data) == 0, "R9 first byte at zero", int'(rd_data), 0);
    end
    chk(int'(rd_data) == D - 1, "R8 last kept byte", int'(rd_data), D - 1);
    pulse_release();
    clr_rx_flag = 1; tick(); clr_rx_flag = 0;

    // R8/R4: zero-length packet with interrupts off
    irq_en = 0;
    send(0, 0);
    repeat (2) tick();
    chk(cpu_owns == 1 && byte_cnt == 0, "R8 zero length", int'(byte_cnt), 0);
    chk(rx_flag == 1 && irq == 0, "R4 irq masked", int'(irq), 0);
    pulse_release();
    repeat (3) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule